// File: doc/BRIEF.md
# Packed float-to-signed-integer converter

This block converts packed floating-point data to signed integers. It rounds to the nearest integer, and a tie goes to the even neighbour. A 128-bit source holds lanes of half, single or double precision. Each lane becomes a two's-complement integer of the same width, placed in the same bit positions. In vector mode a quad select chooses whether the lower 64 bits or all 128 bits are converted. In scalar mode only the lowest element is converted. The bits above it then come either from the previous destination value (merge) or are cleared.

Each lane reports two exception conditions: invalid and inexact. The block ORs each condition across the active lanes. A per-exception enable decides where each condition goes: it is either reported on its status flag or turned into a trap request. Caller-side logic accumulates the flags into a sticky register. One encoding is reserved: vector mode with 64-bit elements in a 64-bit operand. For that encoding the block raises an undefined indication and writes nothing. The datapath is combinational, followed by one output register. With the default parameters every result appears one clock after its inputs.

Top module: `pkcvt_rne`

## Requirements
- R1: Every element is rounded to the nearest integer. A value exactly halfway between two integers goes to the even one, so 2.5 gives 2, 3.5 gives 4 and -2.5 gives -2.
- R2: Element width is 16 bits when `half_i`=1. Otherwise it is 32 bits for `size_i`=0 and 64 bits for `size_i`=1. Each result is a two's-complement integer of that width, written at the bit position its source element occupied.
- R3: In vector mode the operand is 64 bits wide when `quad_i`=0 and 128 bits wide when `quad_i`=1. Lane `k` occupies bits `[k*w +: w]`, and the lane count is the operand width divided by the element width. Result bits above the operand are zero, even with `merge_i`=1. Exceptions from lanes outside the operand are ignored.
- R4: In scalar mode only the element in bits `[w-1:0]` is converted, and `quad_i` is ignored. The bits above it take `dst_old_i` when `merge_i`=1 and are zero otherwise.
- R5: Vector mode with `half_i`=0, `size_i`=1 and `quad_i`=0 is reserved. `undef_o` is then 1 and the result, both flags and `trap_o` are 0. The same selects in scalar mode are legal.
- R6: A NaN input (exponent all ones, fraction non-zero) converts to 0 and raises invalid.
- R7: Infinities and finite values whose rounded result does not fit saturate to the largest positive or most negative value of the element width, and raise invalid. Exactly -2^(w-1) is representable and raises nothing.
- R8: A finite, non-invalid input that is not an integer raises inexact. Subnormal inputs give 0 with inexact. Invalid and inexact are never raised together by one lane.
- R9: `trap_en_i[0]` enables the invalid trap and `trap_en_i[1]` the inexact trap. An enabled condition drives `trap_o`=1 and keeps its flag at 0. A disabled condition drives its flag (`flag_invalid_o`, `flag_inexact_o`).
- R10: All outputs are registered and appear one clock after the inputs. A synchronous active-high reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 128 | Packed floating-point source |
| dst_old_i | input | 128 | Previous destination contents for scalar merge |
| half_i | input | 1 | 1 selects half-precision lanes |
| size_i | input | 1 | With half_i=0: 0 single, 1 double |
| quad_i | input | 1 | Vector mode: 0 for a 64-bit operand, 1 for 128-bit |
| scalar_i | input | 1 | 1 converts only the lowest element |
| merge_i | input | 1 | Scalar mode: keep upper destination bits |
| trap_en_i | input | 2 | Trap enables: bit 0 invalid, bit 1 inexact |
| res_o | output | 128 | Converted result |
| flag_invalid_o | output | 1 | Invalid reported as a status flag |
| flag_inexact_o | output | 1 | Inexact reported as a status flag |
| trap_o | output | 1 | Trap request |
| undef_o | output | 1 | Reserved encoding was requested |

## Verification
Every output of this block, including the flags, trap and undefined indication, is due exactly one rising edge after the inputs that produced it. The bench drives inputs at the falling edge and samples 1 ns after the next rising edge, so each comparison sees exactly the operation just applied. In one case the bench also samples between a new input and its edge, to confirm that the previous result is still held. Expected lane values come from a bench model that finds the remainder and compares it with one half; this is not the shift-and-round-bit scheme the RTL uses.

// File: rtl/fcv_pkg.sv
package fcv_pkg;
  localparam int HALF_EW = 5;
  localparam int HALF_MW = 10;
  localparam int SGL_EW  = 8;
  localparam int SGL_MW  = 23;
  localparam int DBL_EW  = 11;
  localparam int DBL_MW  = 52;

  typedef enum logic [1:0] {FMT_H, FMT_S, FMT_D} fmt_e;

  typedef struct packed {
    logic inv;
    logic inx;
  } exc_t;
endpackage

// File: rtl/fcv_lane.sv
// One float lane to signed integer, round to nearest even, combinational.
module fcv_lane #(
  parameter int EW = 5,
  parameter int MW = 10,
  parameter int IW = 16,
  localparam int FW = EW + MW + 1
) (
  input  logic [FW-1:0] f_i,
  output logic [IW-1:0] q_o,
  output logic          inv_o,
  output logic          inx_o
);
  localparam int BIAS = (1 << (EW - 1)) - 1;
  localparam int F    = MW + 1;           // fraction bits of the fixed-point view
  localparam int TW   = IW + F;
  localparam int SW   = $clog2(IW + 1);
  localparam int EXW  = EW + 2;
  localparam logic [IW:0] LIM  = {2'b01, {(IW-1){1'b0}}};
  localparam logic [IW-1:0] MAXV = {1'b0, {(IW-1){1'b1}}};
  localparam logic [IW-1:0] MINV = {1'b1, {(IW-1){1'b0}}};

  logic                  sgn, tiny, big, nan, inf, rb, st, up, ovf;
  logic [EW-1:0]         ex;
  logic [MW-1:0]         man;
  logic [F-1:0]          sig;
  logic signed [EXW-1:0] e, ep1;
  logic [SW-1:0]         shamt;
  logic [TW-1:0]         xs;
  logic [IW-1:0]         ip;
  logic [IW:0]           mag;

  always_comb begin
    sgn   = f_i[FW-1];
    ex    = f_i[FW-2:MW];
    man   = f_i[MW-1:0];
    sig   = {|ex, man};
    e     = $signed({2'b00, ex}) - EXW'(BIAS);
    if (ex == '0) e = EXW'(1 - BIAS);
    ep1   = e + EXW'(1);
    tiny  = e < EXW'(-1);
    big   = e > EXW'(IW - 1);
    shamt = (tiny || big) ? '0 : ep1[SW-1:0];
    xs    = {{IW{1'b0}}, sig} << shamt;
    ip    = xs[TW-1:F];
    rb    = xs[F-1];
    st    = |xs[F-2:0];
    if (tiny) begin
      ip = '0;
      rb = 1'b0;
      st = |sig;
    end
    up  = rb & (st | ip[0]);
    mag = {1'b0, ip} + {{IW{1'b0}}, up};
    ovf = big | (sgn ? (mag > LIM) : (mag >= LIM));
    nan = (&ex) & (|man);
    inf = (&ex) & ~(|man);
    if (nan) begin
      q_o = '0; inv_o = 1'b1; inx_o = 1'b0;
    end else if (inf || ovf) begin
      q_o = sgn ? MINV : MAXV; inv_o = 1'b1; inx_o = 1'b0;
    end else begin
      q_o = sgn ? (~mag[IW-1:0] + 1'b1) : mag[IW-1:0];
      inv_o = 1'b0;
      inx_o = rb | st;
    end
  end

  always_comb begin
    AST_INV_INX_EXCL: assert (!(inv_o && inx_o)); // R8
  end
endmodule

// File: rtl/fcv_bank.sv
// All lanes of one element format, masked to the active lane count.
module fcv_bank #(
  parameter int EW   = 5,
  parameter int MW   = 10,
  parameter int IW   = 16,
  parameter int VLEN = 128,
  localparam int N   = VLEN / IW,
  localparam int CW  = $clog2(N + 1)
) (
  input  logic [VLEN-1:0] src_i,
  input  logic [CW-1:0]   nact_i,
  output logic [VLEN-1:0] q_o,
  output logic [VLEN-1:0] wmask_o,
  output logic            inv_o,
  output logic            inx_o
);
  logic [N-1:0] linv, linx;

  for (genvar g = 0; g < N; g++) begin : g_lane
    logic [IW-1:0] lq;
    logic          li, lx, act;
    fcv_lane #(.EW(EW), .MW(MW), .IW(IW)) u_lane (
      .f_i  (src_i[g*IW +: IW]),
      .q_o  (lq),
      .inv_o(li),
      .inx_o(lx)
    );
    assign act                 = CW'(g) < nact_i;
    assign q_o[g*IW +: IW]     = act ? lq : '0;
    assign wmask_o[g*IW +: IW] = {IW{act}};
    assign linv[g]             = act & li;
    assign linx[g]             = act & lx;
  end

  assign inv_o = |linv;
  assign inx_o = |linx;
endmodule

// File: rtl/pkcvt_rne.sv
module pkcvt_rne
  import fcv_pkg::*;
#(
  parameter int VLEN    = 128,
  parameter bit OUT_REG = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [VLEN-1:0] src_i,
  input  logic [VLEN-1:0] dst_old_i,
  input  logic            half_i,
  input  logic            size_i,
  input  logic            quad_i,
  input  logic            scalar_i,
  input  logic            merge_i,
  input  logic [1:0]      trap_en_i,
  output logic [VLEN-1:0] res_o,
  output logic            flag_invalid_o,
  output logic            flag_inexact_o,
  output logic            trap_o,
  output logic            undef_o
);
  localparam int NH  = VLEN / 16;
  localparam int NS  = VLEN / 32;
  localparam int ND  = VLEN / 64;
  localparam int CWH = $clog2(NH + 1);
  localparam int CWS = $clog2(NS + 1);
  localparam int CWD = $clog2(ND + 1);

  fmt_e            fmt;
  logic            rsv;
  logic [CWH-1:0]  nh;
  logic [CWS-1:0]  ns;
  logic [CWD-1:0]  nd;
  logic [VLEN-1:0] qh, qs, qd, mh, ms, md, q_sel, m_sel, fill;
  exc_t            eh, es, ed, e_sel;
  logic [VLEN-1:0] res_c;
  logic            finv_c, finx_c, trap_c, inv_c, inx_c;

  always_comb begin
    fmt = half_i ? FMT_H : (size_i ? FMT_D : FMT_S);
    rsv = !scalar_i && !half_i && size_i && !quad_i;
    nh  = scalar_i ? CWH'(1) : (quad_i ? CWH'(NH) : CWH'(NH / 2));
    ns  = scalar_i ? CWS'(1) : (quad_i ? CWS'(NS) : CWS'(NS / 2));
    nd  = scalar_i ? CWD'(1) : (quad_i ? CWD'(ND) : CWD'(0));
  end

  fcv_bank #(.EW(HALF_EW), .MW(HALF_MW), .IW(16), .VLEN(VLEN)) u_bank_h (
    .src_i(src_i), .nact_i(nh), .q_o(qh), .wmask_o(mh), .inv_o(eh.inv), .inx_o(eh.inx));
  fcv_bank #(.EW(SGL_EW), .MW(SGL_MW), .IW(32), .VLEN(VLEN)) u_bank_s (
    .src_i(src_i), .nact_i(ns), .q_o(qs), .wmask_o(ms), .inv_o(es.inv), .inx_o(es.inx));
  fcv_bank #(.EW(DBL_EW), .MW(DBL_MW), .IW(64), .VLEN(VLEN)) u_bank_d (
    .src_i(src_i), .nact_i(nd), .q_o(qd), .wmask_o(md), .inv_o(ed.inv), .inx_o(ed.inx));

  always_comb begin
    unique case (fmt)
      FMT_H:   begin q_sel = qh; m_sel = mh; e_sel = eh; end
      FMT_S:   begin q_sel = qs; m_sel = ms; e_sel = es; end
      default: begin q_sel = qd; m_sel = md; e_sel = ed; end
    endcase
    fill   = (scalar_i && merge_i) ? dst_old_i : '0;
    res_c  = rsv ? '0 : ((q_sel & m_sel) | (fill & ~m_sel));
    inv_c  = !rsv && e_sel.inv;
    inx_c  = !rsv && e_sel.inx;
    finv_c = inv_c && !trap_en_i[0];
    finx_c = inx_c && !trap_en_i[1];
    trap_c = (inv_c && trap_en_i[0]) || (inx_c && trap_en_i[1]);
  end

  if (OUT_REG) begin : g_oreg
    always_ff @(posedge clk) begin
      if (rst) begin
        res_o          <= '0;
        flag_invalid_o <= 1'b0;
        flag_inexact_o <= 1'b0;
        trap_o         <= 1'b0;
        undef_o        <= 1'b0;
      end else begin
        res_o          <= res_c;
        flag_invalid_o <= finv_c;
        flag_inexact_o <= finx_c;
        trap_o         <= trap_c;
        undef_o        <= rsv;
      end
    end

    AST_UNDEF_QUIET: assert property (@(posedge clk) disable iff (rst)
      undef_o |-> (res_o == '0 && !trap_o && !flag_invalid_o && !flag_inexact_o)); // R5
    AST_RSV_DECODE: assert property (@(posedge clk) disable iff (rst)
      (!scalar_i && !half_i && size_i && !quad_i) |=> undef_o); // R5
    AST_TRAP_MASKS_INV: assert property (@(posedge clk) disable iff (rst)
      trap_en_i[0] |=> !flag_invalid_o); // R9
    AST_TRAP_MASKS_INX: assert property (@(posedge clk) disable iff (rst)
      trap_en_i[1] |=> !flag_inexact_o); // R9
    AST_SCALAR_ZERO_FILL: assert property (@(posedge clk) disable iff (rst)
      (scalar_i && !merge_i) |=> (res_o[VLEN-1:64] == '0)); // R4
    AST_SCALAR_MERGE: assert property (@(posedge clk) disable iff (rst)
      (scalar_i && merge_i && !half_i && size_i) |=>
      (res_o[VLEN-1:64] == $past(dst_old_i[VLEN-1:64]))); // R4
    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
      (!scalar_i && !quad_i) |=> (res_o[VLEN-1:64] == '0)); // R3
  end else begin : g_ocomb
    assign res_o          = res_c;
    assign flag_invalid_o = finv_c;
    assign flag_inexact_o = finx_c;
    assign trap_o         = trap_c;
    assign undef_o        = rsv;
  end
endmodule

// File: tb/test_pkcvt_rne.sv
module test_pkcvt_rne;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [127:0] src_i = '0, dst_old_i = '0;
  logic         half_i = 0, size_i = 0, quad_i = 0, scalar_i = 0, merge_i = 0;
  logic [1:0]   trap_en_i = '0;
  logic [127:0] res_o;
  logic         flag_invalid_o, flag_inexact_o, trap_o, undef_o;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  pkcvt_rne i_pkcvt_rne (
    .clk(clk), .rst(rst), .src_i(src_i), .dst_old_i(dst_old_i), .half_i(half_i),
    .size_i(size_i), .quad_i(quad_i), .scalar_i(scalar_i), .merge_i(merge_i),
    .trap_en_i(trap_en_i), .res_o(res_o), .flag_invalid_o(flag_invalid_o),
    .flag_inexact_o(flag_inexact_o), .trap_o(trap_o), .undef_o(undef_o));

  function automatic logic [3:0] outflags();
    return {flag_invalid_o, flag_inexact_o, trap_o, undef_o};
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Reference: integer part and remainder, remainder compared against one half.
  task automatic ref_elem(input logic [63:0] b, input int ew, input int mw, input int iw,
                          output logic [63:0] v, output bit inv, output bit inx);
    int bias, ex, e, s;
    logic sgn;
    logic [63:0] man, msk;
    logic [127:0] sig, ip, rem, hv, lim;
    bias = (1 << (ew - 1)) - 1;
    ex   = int'((b >> mw) & ((64'd1 << ew) - 1));
    sgn  = b[ew+mw];
    man  = b & ((64'd1 << mw) - 1);
    msk  = (iw == 64) ? '1 : ((64'd1 << iw) - 1);
    lim  = 128'd1 << (iw - 1);
    inv = 0; inx = 0; v = '0;
    if (ex == (1 << ew) - 1) begin
      inv = 1;
      v = (man != 0) ? 64'd0 : (sgn ? (64'd1 << (iw - 1)) : ((64'd1 << (iw - 1)) - 1));
      return;
    end
    sig = 128'(man) | ((ex != 0) ? (128'd1 << mw) : 128'd0);
    e   = (ex == 0) ? 1 - bias : ex - bias;
    if (e >= iw) ip = lim << 2;
    else if (e >= mw) ip = sig << (e - mw);
    else begin
      s = mw - e;
      if (s >= 120) begin
        ip = '0; inx = (sig != 0);
      end else begin
        ip  = sig >> s;
        rem = sig - (ip << s);
        hv  = 128'd1 << (s - 1);
        inx = (rem != 0);
        if (rem > hv || (rem == hv && ip[0])) ip = ip + 1;
      end
    end
    if ((!sgn && ip >= lim) || (sgn && ip > lim)) begin
      inv = 1; inx = 0;
      v = sgn ? (64'd1 << (iw - 1)) : ((64'd1 << (iw - 1)) - 1);
    end else begin
      v = sgn ? ((~ip[63:0] + 64'd1) & msk) : (ip[63:0] & msk);
    end
  endtask

  task automatic ref_all(input logic h, sz, q, sc, mg, input logic [1:0] te,
                         input logic [127:0] s, d, output logic [127:0] r,
                         output logic [3:0] fl);
    int es, ew, mw, n;
    logic ud, ainv, ainx;
    logic [127:0] em;
    ud = !sc && !h && sz && !q;
    es = h ? 16 : (sz ? 64 : 32);
    ew = h ? 5 : (sz ? 11 : 8);
    mw = h ? 10 : (sz ? 52 : 23);
    n  = sc ? 1 : (q ? 128 / es : 64 / es);
    em = (128'd1 << es) - 1;
    r = '0; ainv = 0; ainx = 0;
    if (!ud) begin
      for (int l = 0; l < n; l++) begin
        logic [63:0] v;
        bit i, x;
        ref_elem(64'((s >> (l * es)) & em), ew, mw, es, v, i, x);
        r = r | ((128'(v) & em) << (l * es));
        ainv |= i; ainx |= x;
      end
      if (sc && mg) r = r | (d & ~em);
    end
    fl = {ainv & !te[0], ainx & !te[1], (ainv & te[0]) | (ainx & te[1]), ud};
  endtask

  task automatic run(input string tag, input logic h, sz, q, sc, mg, input logic [1:0] te,
                     input logic [127:0] s, d);
    logic [127:0] er;
    logic [3:0]   ef;
    @(negedge clk);
    half_i = h; size_i = sz; quad_i = q; scalar_i = sc; merge_i = mg;
    trap_en_i = te; src_i = s; dst_old_i = d;
    ref_all(h, sz, q, sc, mg, te, s, d, er, ef);
    @(posedge clk); #1;
    chk({tag, " result"}, res_o, er);
    chk({tag, " flags"}, 128'(outflags()), 128'(ef));
  endtask

  function automatic logic [63:0] gen_elem(int ew, int mw, int iw);
    logic [63:0] b, man;
    int bias, ex;
    bias = (1 << (ew - 1)) - 1;
    b    = {$urandom, $urandom};
    man  = b & ((64'd1 << mw) - 1);
    case ($urandom % 4)
      0: return b;
      1: ex = bias + int'($urandom % (iw + 3)) - 3;
      2: begin
        ex  = bias + int'($urandom % 12) - 2;
        man = man & ~((64'd1 << (mw - 4)) - 1);
      end
      default: ex = ($urandom % 3 == 0) ? 0 : bias - 1 + int'($urandom % 4);
    endcase
    return (64'(b[63]) << (ew + mw)) | (64'(ex) << mw) | man;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    chk("R10 reset result", res_o, '0);
    chk("R10 reset flags", 128'(outflags()), '0);

    // R1: ties to even, half vector 128-bit
    run("R1 ties", 1, 0, 1, 0, 0, 2'b00,
        {16'h0001, 16'h3C00, 16'hC300, 16'h3E00, 16'h3800, 16'hC100, 16'h4300, 16'h4100}, '0);
    chk("R1 ties literal", res_o,
        {16'h0000, 16'h0001, 16'hFFFC, 16'h0002, 16'h0000, 16'hFFFE, 16'h0004, 16'h0002});
    chk("R8 inexact literal", 128'(outflags()), 128'(4'b0100));

    // R10: result held until the next edge
    @(negedge clk); src_i = '0; #1;
    chk("R10 hold", res_o,
        {16'h0000, 16'h0001, 16'hFFFC, 16'h0002, 16'h0000, 16'hFFFE, 16'h0004, 16'h0002});

    // R2: double lanes
    run("R2 double", 0, 1, 1, 0, 0, 2'b00, {64'hC00C000000000000, 64'h4004000000000000}, '0);
    chk("R2 double literal", res_o, {64'hFFFFFFFFFFFFFFFC, 64'h2});

    // R3: 64-bit single operand, upper bits zero despite merge, upper NaN ignored
    run("R3 narrow", 0, 0, 0, 0, 1, 2'b00,
        {32'h7FC00000, 32'h41200000, 32'hBF000000, 32'h3FC00000}, '1);
    chk("R3 narrow literal", res_o, {64'd0, 32'h0, 32'h2});
    chk("R3 inactive lane flags", 128'(outflags()), 128'(4'b0100));

    // R4: scalar merge / zero, quad ignored
    run("R4 merge", 0, 1, 0, 1, 1, 2'b00, {64'h7FF8000000000000, 64'h4004000000000000}, '1);
    chk("R4 merge literal", res_o, {64'hFFFFFFFFFFFFFFFF, 64'h2});
    run("R4 zero", 0, 1, 1, 1, 0, 2'b00, {64'h4004000000000000, 64'h4004000000000000}, '1);
    chk("R4 zero literal", res_o, {64'd0, 64'h2});
    run("R4 half merge", 1, 0, 1, 1, 1, 2'b00, {112'd0, 16'h4300}, {8{16'hA5A5}});
    chk("R4 half merge literal", res_o, {{7{16'hA5A5}}, 16'h0004});

    // R5: reserved vs legal scalar
    run("R5 reserved", 0, 1, 0, 0, 1, 2'b11, {2{64'h7FF8000000000000}}, '1);
    chk("R5 reserved literal", {res_o[123:0], outflags()}, 128'(4'b0001));
    run("R5 scalar legal", 0, 1, 0, 1, 0, 2'b00, {64'd0, 64'h4004000000000000}, '0);

    // R6: NaN
    run("R6 nan", 0, 0, 1, 0, 0, 2'b00, {4{32'h7FC00001}}, '0);
    chk("R6 nan literal", {res_o[123:0], outflags()}, 128'(4'b1000));

    // R7: saturation and the exact negative limit
    run("R7 sat half", 1, 0, 0, 0, 0, 2'b00, {64'd0, 16'h7BFF, 16'hFC00, 16'h7C00, 16'h7800}, '0);
    chk("R7 sat half literal", res_o, {64'd0, 16'h7FFF, 16'h8000, 16'h7FFF, 16'h7FFF});
    run("R7 exact min", 1, 0, 0, 1, 0, 2'b00, {112'd0, 16'hF800}, '0);
    chk("R7 exact min literal", {res_o[123:0], outflags()}, {108'd0, 16'h8000, 4'b0000});
    run("R7 sat single", 0, 0, 1, 0, 0, 2'b00, {32'h4F000000, 32'hCF000000, 32'h4F32D05E, 32'hFF800000}, '0);
    run("R7 sat double", 0, 1, 1, 0, 0, 2'b00, {64'hC3E0000000000000, 64'h43E0000000000000}, '0);

    // R8: subnormals and exact values
    run("R8 subnormal", 1, 0, 0, 1, 0, 2'b00, {112'd0, 16'h83FF}, '0);
    chk("R8 subnormal literal", {res_o[123:0], outflags()}, 128'(4'b0100));
    run("R8 exact", 0, 0, 1, 0, 0, 2'b00, {32'h40400000, 32'hC0400000, 32'h00000000, 32'h80000000}, '0);
    chk("R8 exact literal", 128'(outflags()), '0);

    // R9: traps
    run("R9 inv trap", 0, 0, 1, 1, 0, 2'b01, {96'd0, 32'h7FC00000}, '0);
    chk("R9 inv trap literal", 128'(outflags()), 128'(4'b0010));
    run("R9 inx trap", 1, 0, 1, 1, 0, 2'b10, {112'd0, 16'h4100}, '0);
    chk("R9 inx trap literal", 128'(outflags()), 128'(4'b0010));
    run("R9 inx flag", 1, 0, 1, 1, 0, 2'b01, {112'd0, 16'h4100}, '0);
    chk("R9 inx flag literal", 128'(outflags()), 128'(4'b0100));

    // Random mix
    for (int it = 0; it < 1500; it++) begin
      logic h, sz, q, sc, mg;
      logic [1:0] te;
      logic [127:0] s, d;
      int es, ew, mw;
      h  = ($urandom % 3) == 0;
      sz = $urandom[0];
      q  = ($urandom % 4) != 0;
      sc = ($urandom % 4) == 0;
      mg = $urandom[0];
      te = (($urandom % 4) == 0) ? 2'($urandom) : 2'b00;
      es = h ? 16 : (sz ? 64 : 32);
      ew = h ? 5 : (sz ? 11 : 8);
      mw = h ? 10 : (sz ? 52 : 23);
      s  = '0;
      d  = {$urandom, $urandom, $urandom, $urandom};
      for (int l = 0; l < 128 / es; l++)
        s = s | ((128'(gen_elem(ew, mw, es)) & ((128'd1 << es) - 1)) << (l * es));
      run("R1/R2/R3/R4 random", h, sz, q, sc, mg, te, s, d);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule